// File: doc/BRIEF.md
# Two-Cycle Static RAM Controller Slave

This block is a bus slave that sits between a pipelined master and an asynchronous static RAM. The RAM needs two system clock cycles per access. The master starts a transaction with a single-cycle read or write command that carries a word address and, for a write, 32 bits of data. The slave reports progress on a 2-bit ready counter. The count tells the master how many cycles remain before the transaction ends, so the master can plan its next step ahead of time. A count of 0 means the read result is valid or the write is complete.

All signals on the RAM side come from registers. Address, write data, the data-drive enable, chip select and output enable are captured on the rising edge that ends the command cycle. The write strobe comes from a flop clocked on the falling edge, so a write fits into two cycles. Read data from the RAM is captured in an input register and held for the master. The slave reports a fixed read overlap level of 2: the next read may be issued one cycle before the current result appears. Because the RAM samples the address only in the two cycles after a command, no second address register is needed. Writes never overlap.

Top module: `sram2c_slave`

## Requirements
- R1: While reset is asserted and after it is released, `rdy_cnt` is 0, `rd_data` is 0, and `ram_cs_n`, `ram_oe_n` and `ram_we_n` are all 1.
- R2: A read accepted in cycle C makes `rdy_cnt` read 2 in cycle C+1, 1 in C+2 and 0 in C+3. In C+3, `rd_data` carries the RAM word at the read address.
- R3: In the two cycles after an accepted read, `ram_cs_n` and `ram_oe_n` are 0 and `ram_addr` holds the command address.
- R4: A write accepted in cycle C makes `rdy_cnt` read 1 in C+1 and 0 in C+2. In both cycles, `ram_addr` and `ram_wdata` hold the command values, `ram_drive` is 1 and `ram_cs_n` is 0.
- R5: `ram_we_n` falls on the falling clock edge inside C+1 and rises on the falling edge inside C+2. `ram_we_n` is never 0 unless `ram_cs_n` is 0 and `ram_drive` is 1.
- R6: A read is accepted while `rdy_cnt` is 1 during a read. The result of the earlier read still appears in the next cycle, and the new read's counter then runs 2, 1, 0. Each result is held for two cycles.
- R7: While no transaction is accepted and `rdy_cnt` is 0, `rdy_cnt` stays 0 and `rd_data` keeps its value.
- R8: A command is accepted only when `rdy_cnt` is 0, or (reads only) as in R6. Any other command has no effect on the RAM, the counter or the read data. If read and write are requested together, the read is taken and the write is dropped.
- R9: One cycle after an idle cycle with no command, `ram_cs_n` and `ram_oe_n` are 1, and `ram_we_n` is 1.
- R10: `rd_pipe_lvl` is constant 2 and `wr_pipe_lvl` is constant 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_rd | input | 1 | Single-cycle read command |
| cmd_wr | input | 1 | Single-cycle write command |
| cmd_addr | input | ADDR_W | Word address, valid with a command |
| cmd_wdata | input | DATA_W | Write data, valid with a write command |
| rd_data | output | DATA_W | Registered read result |
| rdy_cnt | output | 2 | Cycles left in the current transaction |
| rd_pipe_lvl | output | 2 | Read overlap level (constant 2) |
| wr_pipe_lvl | output | 2 | Write overlap level (constant 0) |
| ram_addr | output | ADDR_W | Registered RAM address |
| ram_wdata | output | DATA_W | Registered RAM write data |
| ram_drive | output | 1 | Enables the data pad driver during a write |
| ram_rdata | input | DATA_W | Data returned by the RAM |
| ram_cs_n | output | 1 | Registered chip select, active low |
| ram_oe_n | output | 1 | Registered output enable, active low |
| ram_we_n | output | 1 | Falling-edge write strobe, active low |

## Verification
The hardest case to reach is the overlapped read. A new read lands in the very cycle the previous result is being captured, and the address register is reloaded on that same edge. The stimulus issues reads on alternate cycles through a run of addresses that were written earlier with distinct values. A reference model compares every held result against its address on every cycle. Illegal commands are sent in each busy phase: a read at count 2, a write during the last read cycle, and read/write pairs during a write. Later reads of the targeted addresses then show that nothing reached the RAM.

// File: rtl/sram2c_pkg.sv
package sram2c_pkg;
  localparam int RDY_W = 2;
  localparam int LVL_W = 2;
  localparam logic [LVL_W-1:0] RD_OVERLAP = 2'd2;
  localparam logic [LVL_W-1:0] WR_OVERLAP = 2'd0;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_RD_A = 3'd1,
    PH_RD_B = 3'd2,
    PH_WR_A = 3'd3,
    PH_WR_B = 3'd4
  } phase_t;
endpackage

// File: rtl/sram2c_rst_sync.sv
module sram2c_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/sram2c_seq.sv
module sram2c_seq
  import sram2c_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_rd,
  input  logic             cmd_wr,
  output phase_t           phase,
  output logic             take_rd,
  output logic             take_wr,
  output logic             cap_en,
  output logic [RDY_W-1:0] rdy_cnt
);
  phase_t phase_q, phase_d;
  logic   free_slot;

  always_comb begin
    free_slot = (phase_q == PH_IDLE) || (phase_q == PH_WR_B);
    take_rd   = cmd_rd && (free_slot || (phase_q == PH_RD_B));
    take_wr   = cmd_wr && !cmd_rd && free_slot;
  end

  always_comb begin
    phase_d = PH_IDLE;
    if (take_rd)                 phase_d = PH_RD_A;
    else if (take_wr)            phase_d = PH_WR_A;
    else if (phase_q == PH_RD_A) phase_d = PH_RD_B;
    else if (phase_q == PH_WR_A) phase_d = PH_WR_B;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  always_comb begin
    unique case (phase_q)
      PH_RD_A: rdy_cnt = 2'd2;
      PH_RD_B: rdy_cnt = 2'd1;
      PH_WR_A: rdy_cnt = 2'd1;
      default: rdy_cnt = 2'd0;
    endcase
  end

  assign cap_en = (phase_q == PH_RD_B);
  assign phase  = phase_q;
endmodule

// File: rtl/sram2c_pins.sv
module sram2c_pins
  import sram2c_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_t            phase,
  input  logic              take_rd,
  input  logic              take_wr,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              ram_drive,
  output logic              ram_cs_n,
  output logic              ram_oe_n,
  output logic              ram_we_n
);
  logic              addr_en, data_en;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              drive_d, cs_n_d, oe_n_d, we_n_d;
  logic              drive_q, cs_n_q, oe_n_q, we_n_q;

  always_comb begin
    addr_en = take_rd || take_wr;
    data_en = take_wr;
    drive_d = take_wr || (phase == PH_WR_A);
    cs_n_d  = !(take_rd || take_wr || (phase == PH_RD_A) || (phase == PH_WR_A));
    oe_n_d  = !(take_rd || (phase == PH_RD_A));
    we_n_d  = !(phase == PH_WR_A);
  end

  always_ff @(posedge clk) begin
    if (addr_en) addr_q <= cmd_addr;
  end

  always_ff @(posedge clk) begin
    if (data_en) wdata_q <= cmd_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= 1'b0;
      cs_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
    end else begin
      drive_q <= drive_d;
      cs_n_q  <= cs_n_d;
      oe_n_q  <= oe_n_d;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) we_n_q <= 1'b1;
    else        we_n_q <= we_n_d;
  end

  assign ram_addr  = addr_q;
  assign ram_wdata = wdata_q;
  assign ram_drive = drive_q;
  assign ram_cs_n  = cs_n_q;
  assign ram_oe_n  = oe_n_q;
  assign ram_we_n  = we_n_q;
endmodule

// File: rtl/sram2c_rdcap.sv
module sram2c_rdcap #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_q <= '0;
    else if (cap_en) hold_q <= ram_rdata;
  end

  assign rd_data = hold_q;
endmodule

// File: rtl/sram2c_slave.sv
module sram2c_slave
  import sram2c_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_rd,
  input  logic              cmd_wr,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        rdy_cnt,
  output logic [1:0]        rd_pipe_lvl,
  output logic [1:0]        wr_pipe_lvl,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              ram_drive,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              ram_cs_n,
  output logic              ram_oe_n,
  output logic              ram_we_n
);
  logic   srst_n;
  phase_t phase;
  logic   take_rd, take_wr, cap_en;

  sram2c_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  sram2c_seq u_seq (
    .clk     (clk),
    .rst_n   (srst_n),
    .cmd_rd  (cmd_rd),
    .cmd_wr  (cmd_wr),
    .phase   (phase),
    .take_rd (take_rd),
    .take_wr (take_wr),
    .cap_en  (cap_en),
    .rdy_cnt (rdy_cnt)
  );

  sram2c_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk       (clk),
    .rst_n     (srst_n),
    .phase     (phase),
    .take_rd   (take_rd),
    .take_wr   (take_wr),
    .cmd_addr  (cmd_addr),
    .cmd_wdata (cmd_wdata),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .ram_drive (ram_drive),
    .ram_cs_n  (ram_cs_n),
    .ram_oe_n  (ram_oe_n),
    .ram_we_n  (ram_we_n)
  );

  sram2c_rdcap #(.DATA_W(DATA_W)) u_cap (
    .clk       (clk),
    .rst_n     (srst_n),
    .cap_en    (cap_en),
    .ram_rdata (ram_rdata),
    .rd_data   (rd_data)
  );

  assign rd_pipe_lvl = RD_OVERLAP;
  assign wr_pipe_lvl = WR_OVERLAP;
endmodule

// File: rtl/sram2c_slave_chk.sv
module sram2c_slave_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_rd,
  input logic              cmd_wr,
  input logic [1:0]        rdy_cnt,
  input logic [DATA_W-1:0] rd_data,
  input logic              ram_cs_n,
  input logic              ram_oe_n,
  input logic              ram_we_n,
  input logic              ram_drive
);
  a_r2_read_starts_at_two: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rd && rdy_cnt == 2'd0) |=> (rdy_cnt == 2'd2));

  a_r2_two_then_one: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_cnt == 2'd2) |=> (rdy_cnt == 2'd1));

  a_r3_read_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rd && rdy_cnt == 2'd0) |=> (!ram_cs_n && !ram_oe_n));

  a_r4_write_counts_one: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !cmd_rd && rdy_cnt == 2'd0) |=> (rdy_cnt == 2'd1 && ram_drive && !ram_cs_n));

  a_r5_we_inside_select: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> (!ram_cs_n && ram_drive));

  a_r6_overlap_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rd && rdy_cnt == 2'd1 && !ram_oe_n) |=> (rdy_cnt == 2'd2));

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_cnt == 2'd0 && !cmd_rd && !cmd_wr) |=> (rdy_cnt == 2'd0 && $stable(rd_data)));

  a_r8_write_dropped_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_cnt == 2'd1 && cmd_wr && !cmd_rd) |=> (rdy_cnt == 2'd0));

  a_r9_idle_strobes_off: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_cnt == 2'd0 && !cmd_rd && !cmd_wr) |=> (ram_cs_n && ram_oe_n && ram_we_n));
endmodule

bind sram2c_slave sram2c_slave_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_rd    (cmd_rd),
  .cmd_wr    (cmd_wr),
  .rdy_cnt   (rdy_cnt),
  .rd_data   (rd_data),
  .ram_cs_n  (ram_cs_n),
  .ram_oe_n  (ram_oe_n),
  .ram_we_n  (ram_we_n),
  .ram_drive (ram_drive)
);

// File: tb/sram2c_slave_bench.sv
module sram2c_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 18;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_rd, cmd_wr;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_wdata;
  logic [DW-1:0] rd_data;
  logic [1:0]    rdy_cnt, rd_pipe_lvl, wr_pipe_lvl;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata;
  logic          ram_drive;
  logic [DW-1:0] ram_rdata;
  logic          ram_cs_n, ram_oe_n, ram_we_n;

  int compared = 0;
  int mismatched = 0;
  bit chk_on = 1'b0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram2c_slave #(.ADDR_W(AW), .DATA_W(DW)) u_sram2c_slave (
    .clk(clk), .rst_n(rst_n), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rd_data(rd_data),
    .rdy_cnt(rdy_cnt), .rd_pipe_lvl(rd_pipe_lvl), .wr_pipe_lvl(wr_pipe_lvl),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_drive(ram_drive),
    .ram_rdata(ram_rdata), .ram_cs_n(ram_cs_n), .ram_oe_n(ram_oe_n),
    .ram_we_n(ram_we_n)
  );

  function automatic logic [DW-1:0] seed_word(int i);
    return 32'h5A00_0000 + i * 32'h0001_0307;
  endfunction

  // behavioural RAM
  logic [DW-1:0] ram_mem [0:63];
  initial for (int i = 0; i < 64; i++) ram_mem[i] = seed_word(i);
  assign ram_rdata = (!ram_cs_n && !ram_oe_n) ? ram_mem[ram_addr[5:0]] : 32'hBAD0_BAD0;
  always @(posedge ram_we_n) begin
    if (!ram_cs_n && ram_drive) ram_mem[ram_addr[5:0]] = ram_wdata;
  end

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model
  logic [DW-1:0] shadow [0:63];
  initial for (int i = 0; i < 64; i++) shadow[i] = seed_word(i);
  int left = 0;
  int kind = 0;            // 0 none, 1 read, 2 write
  int paddr = 0;
  int quiet = 10;
  int rage = 0, wage = 0;
  logic [AW-1:0] ra, wa;
  logic [DW-1:0] wd;
  logic [DW-1:0] exp_data = '0;

  always @(posedge clk) begin
    if (chk_on) begin
      bit acc_rd, acc_wr;
      acc_rd = cmd_rd && (left == 0 || (left == 1 && kind == 1));
      acc_wr = cmd_wr && !cmd_rd && left == 0;
      if (kind == 1 && left == 1) exp_data = shadow[paddr];
      if (rage > 0 && rage < 9) rage++;
      if (wage > 0 && wage < 9) wage++;
      if (acc_rd) begin
        kind = 1; left = 2; paddr = int'(cmd_addr[5:0]); rage = 1; ra = cmd_addr;
      end else if (acc_wr) begin
        kind = 2; left = 1; shadow[cmd_addr[5:0]] = cmd_wdata; wage = 1;
        wa = cmd_addr; wd = cmd_wdata;
      end else if (left > 0) begin
        left--;
      end
      quiet = (acc_rd || acc_wr) ? 0 : quiet + 1;
      #(CLK_PERIOD/4);
      check("R2/R7 rdy_cnt", {30'd0, rdy_cnt}, left);
      check("R2/R6/R7 rd_data", rd_data, exp_data);
      check("R10 rd level", {30'd0, rd_pipe_lvl}, 32'd2);
      check("R10 wr level", {30'd0, wr_pipe_lvl}, 32'd0);
      if (quiet >= 3)
        check("R9 strobes idle", {29'd0, ram_cs_n, ram_oe_n, ram_we_n}, 32'd7);
      if (rage == 1 || rage == 2) begin
        check("R3 read strobes", {30'd0, ram_cs_n, ram_oe_n}, 32'd0);
        check("R3 read addr", {14'd0, ram_addr}, {14'd0, ra});
      end
      if (wage == 1 || wage == 2) begin
        check("R4 write addr", {14'd0, ram_addr}, {14'd0, wa});
        check("R4 write data", ram_wdata, wd);
        check("R4 drive/cs", {30'd0, ram_drive, ram_cs_n}, 32'd2);
        check("R5 we_n phase", {31'd0, ram_we_n}, (wage == 2) ? 32'd0 : 32'd1);
      end
      if (wage == 3) check("R5 we_n released", {31'd0, ram_we_n}, 32'd1);
    end
  end

  task automatic step(bit r, bit w, int a, logic [DW-1:0] d);
    @(negedge clk);
    cmd_rd = r; cmd_wr = w; cmd_addr = AW'(a); cmd_wdata = d;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, '0);
  endtask

  initial begin
    rst_n = 1'b0; cmd_rd = 0; cmd_wr = 0; cmd_addr = '0; cmd_wdata = '0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    // R1: values during reset
    check("R1 rdy in reset", {30'd0, rdy_cnt}, 32'd0);
    check("R1 rd_data in reset", rd_data, 32'd0);
    check("R1 strobes in reset", {29'd0, ram_cs_n, ram_oe_n, ram_we_n}, 32'd7);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_on = 1'b1;
    idle(3);
    // R4 R5 writes, R2 read, R7 hold
    step(0, 1, 5, 32'hCAFE_0005); idle(1);
    step(0, 1, 9, 32'hCAFE_0009); idle(1);
    step(1, 0, 5, '0); idle(6);
    // R6 overlapped reads
    step(1, 0, 9, '0); idle(1);
    step(1, 0, 5, '0); idle(1);
    step(1, 0, 3, '0); idle(1);
    step(1, 0, 60, '0); idle(5);
    // R8 busy commands ignored
    step(1, 0, 7, '0);
    step(1, 0, 8, '0);
    step(0, 1, 8, 32'hDEAD_0008); idle(3);
    step(1, 0, 8, '0); idle(4);
    step(0, 1, 10, 32'hCAFE_0010);
    step(1, 1, 11, 32'hDEAD_0011);
    step(0, 1, 12, 32'hCAFE_0012); idle(1);
    step(1, 0, 11, '0); idle(4);
    step(1, 1, 12, 32'hDEAD_1212); idle(3);
    step(1, 0, 12, '0); idle(4);
    // read right after write completes
    step(0, 1, 20, 32'hCAFE_0020);
    idle(1);
    step(1, 0, 20, '0); idle(4);
    // sweep: writes then overlapped reads
    for (int i = 0; i < 16; i++) begin
      step(0, 1, i * 3 + 1, 32'h7700_0000 + i * 32'h1111);
      idle(1);
    end
    for (int i = 0; i < 16; i++) begin
      step(1, 0, i * 3 + 1, '0);
      idle(1);
    end
    idle(6);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1'b1;
      compared++; mismatched++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule